// File: doc/BRIEF.md
# Dual-Bank Byte-Lane Memory Port

This block joins a 16-bit request port to a memory that is split into two byte-wide banks. One bank holds every byte at an even address and the other holds every byte at an odd address. Each request carries a 20-bit byte address, a size flag (byte or word), a direction and 16 bits of write data. The block turns each request into one or two bank cycles. For each cycle it drives the byte address, an active-low high-lane enable and the bank strobes. Write data is placed on the byte lanes the banks expect, and read data is taken from those lanes and put back in the right order.

A word at an odd address does not fit a single bank cycle. The block splits it into two cycles. The first goes to the odd bank and carries the low byte. The second goes to the even bank at the next address and carries the high byte. The block also decodes two regions. A ROM region sits at the top of the address space and a RAM region at the bottom, and each region has its own chip select. The ROM region refuses writes. Addresses outside both regions read back as all ones.

Top module: `dual_bank_port`

## Requirements
- R1: After reset, req_ready=1, cyc_act=0, done=0, wr_err=0 and rdata=0000h.
- R2: A byte access at an even address is one bank cycle with hi_en_n=1 and mem_addr[0]=0. A write places the byte (req_wdata[7:0]) on mem_wdata[7:0] with mem_wdata[15:8]=00h. A read returns {00h, mem_rdata[7:0]}. No bank cycle ever has hi_en_n=1 together with mem_addr[0]=1.
- R3: A byte access at an odd address is one bank cycle with hi_en_n=0 and mem_addr[0]=1. A write places req_wdata[7:0] on mem_wdata[15:8] with mem_wdata[7:0]=00h. A read returns {00h, mem_rdata[15:8]}.
- R4: A word access at an even address is one bank cycle with hi_en_n=0 and mem_addr[0]=0. Write data uses all 16 lanes unchanged, and a read returns mem_rdata unchanged.
- R5: A word access at an odd address A takes two consecutive bank cycles, and req_ready=0 during the first. The first cycle uses mem_addr=A, hi_en_n=0, with req_wdata[7:0] on mem_wdata[15:8]. The second uses mem_addr=A+1 (modulo 2^20), hi_en_n=1, with req_wdata[15:8] on mem_wdata[7:0].
- R6: A split read returns the byte taken from mem_rdata[15:8] in the first cycle as rdata[7:0], and the byte taken from mem_rdata[7:0] in the second cycle as rdata[15:8].
- R7: A request is accepted on a clock edge where req_valid=1 and req_ready=1. The first bank cycle (cyc_act=1) occupies the next clock cycle. done is high for one cycle right after the last bank cycle, and rdata holds the read result from then on. A new request can be accepted on the edge that ends the last bank cycle, so its bank cycle coincides with the previous done.
- R8: During a bank cycle, rom_cs is high for addresses in the top ROM_BYTES of the space (default F0000h-FFFFFh) and ram_cs is high for addresses in the bottom RAM_BYTES (default 00000h-0FFFFh). Each cycle of a split access is decoded on its own address. Outside bank cycles, both selects are low.
- R9: A write bank cycle whose address is in the ROM region has mem_we=0 and rom_cs=0, and raises wr_err for exactly that cycle. The access still completes with done, and ROM contents are unchanged. Reads from ROM work normally.
- R10: A bank cycle whose address is in neither region raises no chip select and reads both lanes as FFh, so a word read returns FFFFh and a byte read returns 00FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_addr | input | 20 | Byte address |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Assembled read result |
| wr_err | output | 1 | Write to the ROM region refused in this bank cycle |
| cyc_act | output | 1 | A bank cycle is on the bus this cycle |
| mem_addr | output | 20 | Bank cycle byte address; bit 0 selects the even bank when 0 |
| hi_en_n | output | 1 | Active-low enable for the odd bank and lanes 15:8 |
| mem_we | output | 1 | Write strobe for the bank cycle |
| mem_wdata | output | 16 | Write data on the byte lanes |
| mem_rdata | input | 16 | Read data from the byte lanes |
| rom_cs | output | 1 | ROM region select |
| ram_cs | output | 1 | RAM region select |

## Verification
The completion of one access and the bank cycle of the next request can occur in the same clock. The done pulse and rdata of the first access then appear while mem_addr, the enables and possibly wr_err belong to the second. The bench provokes this by keeping req_valid high with fresh fields during the final bank cycle of a word write, with a byte write into ROM queued behind it. In that one sample it checks the first access's done, and the second access's address, the suppressed write strobe and the error flag. A later read then confirms that the first write reached memory.

// File: rtl/dbp_pkg.sv
package dbp_pkg;

  localparam int LANE_W = 8;
  localparam int LANES  = 2;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ONE    = 2'd1,
    PH_FIRST  = 2'd2,
    PH_SECOND = 2'd3
  } phase_t;

  // Byte driven onto one lane for a write; idle lanes carry zero.
  function automatic logic [7:0] wr_lane_byte(phase_t ph, logic word, logic a0,
                                              int lane, logic [15:0] wd);
    logic [7:0] b;
    b = 8'h00;
    case (ph)
      PH_ONE: begin
        if (word)                 b = wd[lane*8 +: 8];
        else if (a0 == lane[0])   b = wd[7:0];
      end
      PH_FIRST:  if (lane == 1) b = wd[7:0];
      PH_SECOND: if (lane == 0) b = wd[15:8];
      default:   b = 8'h00;
    endcase
    return b;
  endfunction

  // Active-low high-lane enable for the current bank cycle.
  function automatic logic hi_lane_off(phase_t ph, logic word, logic a0);
    case (ph)
      PH_ONE:   return !(word || a0);
      PH_FIRST: return 1'b0;
      default:  return 1'b1;
    endcase
  endfunction

  // Result of a single-cycle read taken from the lanes.
  function automatic logic [15:0] rd_single(logic word, logic a0, logic [15:0] lanes);
    if (word)    return lanes;
    else if (a0) return {8'h00, lanes[15:8]};
    else         return {8'h00, lanes[7:0]};
  endfunction

  function automatic logic in_top(logic [31:0] a, logic [31:0] aw, logic [31:0] bytes);
    return (bytes != 32'd0) && (a >= ((32'd1 << aw) - bytes));
  endfunction

  function automatic logic in_bottom(logic [31:0] a, logic [31:0] bytes);
    return a < bytes;
  endfunction

endpackage

// File: rtl/dbp_region_dec.sv
module dbp_region_dec
  import dbp_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int ROM_BYTES = 32'h10000,
  parameter int RAM_BYTES = 32'h10000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              rom_hit,
  output logic              ram_hit
);
  logic [31:0] a32;
  assign a32     = 32'(addr);
  assign rom_hit = in_top(a32, 32'(ADDR_W), 32'(ROM_BYTES));
  assign ram_hit = in_bottom(a32, 32'(RAM_BYTES));
endmodule

// File: rtl/dbp_lane_steer.sv
module dbp_lane_steer
  import dbp_pkg::*;
(
  input  phase_t                   ph,
  input  logic                     word,
  input  logic                     a0,
  input  logic [LANES*LANE_W-1:0]  wdata,
  input  logic                     cs_any,
  input  logic [LANES*LANE_W-1:0]  mem_rdata,
  output logic [LANES*LANE_W-1:0]  mem_wdata,
  output logic [LANES*LANE_W-1:0]  lanes_rd
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign mem_wdata[l*LANE_W +: LANE_W] = wr_lane_byte(ph, word, a0, l, wdata);
    assign lanes_rd[l*LANE_W +: LANE_W]  = cs_any ? mem_rdata[l*LANE_W +: LANE_W]
                                                  : {LANE_W{1'b1}};
  end
endmodule

// File: rtl/dbp_seq.sv
module dbp_seq
  import dbp_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_word,
  input  logic              req_write,
  input  logic [15:0]       req_wdata,
  input  logic [15:0]       lanes_rd,
  output phase_t            ph,
  output logic              r_a0,
  output logic              r_word,
  output logic              r_we,
  output logic [15:0]       r_wdata,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic              req_ready,
  output logic              done,
  output logic [15:0]       rdata
);
  phase_t            ph_d;
  logic [ADDR_W-1:0] r_addr;
  logic [7:0]        lo_byte;
  logic              accept;

  assign req_ready = (ph != PH_FIRST);
  assign accept    = req_valid && req_ready;
  assign cyc_addr  = (ph == PH_SECOND) ? r_addr + ADDR_W'(1) : r_addr;
  assign r_a0      = r_addr[0];

  always_comb begin
    if (accept)                ph_d = (req_word && req_addr[0]) ? PH_FIRST : PH_ONE;
    else if (ph == PH_FIRST)   ph_d = PH_SECOND;
    else                       ph_d = PH_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      r_addr  <= '0;
      r_word  <= 1'b0;
      r_we    <= 1'b0;
      r_wdata <= '0;
      done    <= 1'b0;
      rdata   <= '0;
      lo_byte <= '0;
    end else begin
      ph   <= ph_d;
      done <= (ph == PH_ONE) || (ph == PH_SECOND);
      if (accept) begin
        r_addr  <= req_addr;
        r_word  <= req_word;
        r_we    <= req_write;
        r_wdata <= req_wdata;
      end
      if (!r_we) begin
        case (ph)
          PH_ONE:    rdata   <= rd_single(r_word, r_addr[0], lanes_rd);
          PH_FIRST:  lo_byte <= lanes_rd[15:8];
          PH_SECOND: rdata   <= {lanes_rd[7:0], lo_byte};
          default:   ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dual_bank_port.sv
module dual_bank_port
  import dbp_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int ROM_BYTES = 32'h10000,
  parameter int RAM_BYTES = 32'h10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_word,
  input  logic              req_write,
  input  logic [15:0]       req_wdata,
  output logic              done,
  output logic [15:0]       rdata,
  output logic              wr_err,
  output logic              cyc_act,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              hi_en_n,
  output logic              mem_we,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  output logic              rom_cs,
  output logic              ram_cs
);
  localparam int DATA_W = LANES * LANE_W;

  phase_t            ph;
  logic              r_a0, r_word, r_we;
  logic [DATA_W-1:0] r_wdata, lanes_rd;
  logic [ADDR_W-1:0] cyc_addr;
  logic              rom_hit, ram_hit;

  dbp_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_word(req_word), .req_write(req_write), .req_wdata(req_wdata),
    .lanes_rd(lanes_rd), .ph(ph), .r_a0(r_a0), .r_word(r_word), .r_we(r_we),
    .r_wdata(r_wdata), .cyc_addr(cyc_addr), .req_ready(req_ready),
    .done(done), .rdata(rdata)
  );

  dbp_region_dec #(.ADDR_W(ADDR_W), .ROM_BYTES(ROM_BYTES), .RAM_BYTES(RAM_BYTES)) u_dec (
    .addr(cyc_addr), .rom_hit(rom_hit), .ram_hit(ram_hit)
  );

  dbp_lane_steer u_steer (
    .ph(ph), .word(r_word), .a0(r_a0), .wdata(r_wdata),
    .cs_any(rom_hit || ram_hit), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .lanes_rd(lanes_rd)
  );

  assign cyc_act  = (ph != PH_IDLE);
  assign mem_addr = cyc_addr;
  assign hi_en_n  = hi_lane_off(ph, r_word, r_a0);
  assign wr_err   = cyc_act && r_we && rom_hit;
  assign mem_we   = cyc_act && r_we && !rom_hit;
  assign rom_cs   = cyc_act && rom_hit && !r_we;
  assign ram_cs   = cyc_act && ram_hit;
endmodule

// File: rtl/dbp_checks.sv
module dbp_checks #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              cyc_act,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              hi_en_n,
  input logic              mem_we,
  input logic              rom_cs,
  input logic              ram_cs,
  input logic              wr_err,
  input logic              done
);
  assert_split_tail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_act && !req_ready) |=> (cyc_act && hi_en_n && !mem_addr[0]));

  assert_split_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_act && !req_ready) |=> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

  assert_lane_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_act |-> !(hi_en_n && mem_addr[0]));

  assert_cs_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_cs, ram_cs}));

  assert_cs_in_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_cs || ram_cs) |-> cyc_act);

  assert_rom_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> (cyc_act && !mem_we && !rom_cs));

  assert_done_after_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(cyc_act && req_ready));
endmodule

bind dual_bank_port dbp_checks #(.ADDR_W(ADDR_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .cyc_act(cyc_act),
  .mem_addr(mem_addr), .hi_en_n(hi_en_n), .mem_we(mem_we), .rom_cs(rom_cs),
  .ram_cs(ram_cs), .wr_err(wr_err), .done(done)
);

// File: tb/tb_dual_bank_port.sv
module tb_dual_bank_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_word = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, done, wr_err, cyc_act, hi_en_n, mem_we, rom_cs, ram_cs;
  logic [15:0] rdata, mem_wdata, mem_rdata;
  logic [19:0] mem_addr;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dual_bank_port dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_word(req_word), .req_write(req_write),
    .req_wdata(req_wdata), .done(done), .rdata(rdata), .wr_err(wr_err),
    .cyc_act(cyc_act), .mem_addr(mem_addr), .hi_en_n(hi_en_n), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rom_cs(rom_cs), .ram_cs(ram_cs)
  );

  // Behavioural banks: 512 bytes each, index folds bit 19 with bits 8:1.
  logic [7:0] even_b [512];
  logic [7:0] odd_b  [512];
  logic [8:0] midx;
  assign midx      = {mem_addr[19], mem_addr[8:1]};
  assign mem_rdata = {odd_b[midx], even_b[midx]};
  always @(posedge clk) if (mem_we) begin
    if (!hi_en_n)     odd_b[midx]  <= mem_wdata[15:8];
    if (!mem_addr[0]) even_b[midx] <= mem_wdata[7:0];
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive a request and return at the negedge inside its first bank cycle.
  task automatic start(input logic [19:0] a, input logic w, input logic we, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_word = w; req_write = we; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_done(input string req, input logic [15:0] exp_rd, input bit is_rd);
    @(negedge clk);
    chk(req, "done", done, 1);
    if (is_rd) chk(req, "rdata", rdata, exp_rd);
  endtask

  task automatic read1(input string req, input logic [19:0] a, input logic w, input logic [15:0] exp);
    start(a, w, 1'b0, 16'h0);
    if (w && a[0]) @(negedge clk);
    expect_done(req, exp, 1);
  endtask

  task automatic t_reset;
    chk("R1", "ready", req_ready, 1);
    chk("R1", "cyc_act", cyc_act, 0);
    chk("R1", "done", done, 0);
    chk("R1", "wr_err", wr_err, 0);
    chk("R1", "rdata", rdata, 16'h0000);
  endtask

  task automatic t_byte_even;
    start(20'h00010, 0, 1, 16'hFF5A);
    chk("R2", "hi_en_n", hi_en_n, 1);
    chk("R2", "a0", mem_addr[0], 0);
    chk("R2", "wdata", mem_wdata, 16'h005A);
    chk("R8", "ram_cs", ram_cs, 1);
    @(negedge clk);
    chk("R7", "done", done, 1);
    chk("R7", "cyc_act idle", cyc_act, 0);
    read1("R2", 20'h00010, 0, 16'h005A);
  endtask

  task automatic t_byte_odd;
    start(20'h00011, 0, 1, 16'h00A5);
    chk("R3", "hi_en_n", hi_en_n, 0);
    chk("R3", "a0", mem_addr[0], 1);
    chk("R3", "wdata", mem_wdata, 16'hA500);
    expect_done("R3", 16'h0, 0);
    read1("R3", 20'h00011, 0, 16'h00A5);
    read1("R4", 20'h00010, 1, 16'hA55A);
  endtask

  task automatic t_word_even;
    start(20'h00020, 1, 1, 16'h1234);
    chk("R4", "hi_en_n", hi_en_n, 0);
    chk("R4", "addr", mem_addr, 20'h00020);
    chk("R4", "wdata", mem_wdata, 16'h1234);
    chk("R4", "ready", req_ready, 1);
    @(negedge clk);
    chk("R4", "single cycle done", done, 1);
    chk("R4", "cyc_act idle", cyc_act, 0);
    read1("R4", 20'h00020, 1, 16'h1234);
  endtask

  task automatic t_split;
    start(20'h00031, 1, 1, 16'hBEEF);
    chk("R5", "ready first", req_ready, 0);
    chk("R5", "addr first", mem_addr, 20'h00031);
    chk("R5", "hi_en_n first", hi_en_n, 0);
    chk("R5", "wdata first", mem_wdata, 16'hEF00);
    @(negedge clk);
    chk("R5", "addr second", mem_addr, 20'h00032);
    chk("R5", "hi_en_n second", hi_en_n, 1);
    chk("R5", "wdata second", mem_wdata, 16'h00BE);
    chk("R5", "ready second", req_ready, 1);
    expect_done("R5", 16'h0, 0);
    read1("R6", 20'h00031, 1, 16'hBEEF);
    read1("R6", 20'h00031, 0, 16'h00EF);
    read1("R6", 20'h00032, 0, 16'h00BE);
  endtask

  task automatic t_rom;
    start(20'hF0100, 1, 0, 16'h0);
    chk("R8", "rom_cs", rom_cs, 1);
    chk("R8", "ram_cs", ram_cs, 0);
    expect_done("R9", 16'h2211, 1);
    start(20'hF0100, 1, 1, 16'h0000);
    chk("R9", "wr_err", wr_err, 1);
    chk("R9", "mem_we", mem_we, 0);
    chk("R9", "rom_cs on write", rom_cs, 0);
    @(negedge clk);
    chk("R9", "wr_err one cycle", wr_err, 0);
    chk("R9", "done", done, 1);
    read1("R9", 20'hF0100, 1, 16'h2211);
  endtask

  task automatic t_hole;
    start(20'h80000, 1, 0, 16'h0);
    chk("R10", "rom_cs", rom_cs, 0);
    chk("R10", "ram_cs", ram_cs, 0);
    expect_done("R10", 16'hFFFF, 1);
    read1("R10", 20'h80001, 0, 16'h00FF);
  endtask

  task automatic t_wrap;
    start(20'h00000, 0, 1, 16'h003C);
    expect_done("R5", 16'h0, 0);
    start(20'hFFFFF, 1, 0, 16'h0);
    chk("R8", "rom_cs first", rom_cs, 1);
    chk("R5", "addr first", mem_addr, 20'hFFFFF);
    @(negedge clk);
    chk("R5", "wrap addr", mem_addr, 20'h00000);
    chk("R8", "ram_cs second", ram_cs, 1);
    chk("R8", "rom_cs second", rom_cs, 0);
    expect_done("R6", 16'h3C77, 1);
  endtask

  task automatic t_overlap;
    @(negedge clk);
    req_valid = 1; req_addr = 20'h00040; req_word = 1; req_write = 1; req_wdata = 16'h5555;
    @(negedge clk);
    chk("R7", "first cycle", cyc_act, 1);
    req_addr = 20'hF0000; req_word = 0; req_write = 1; req_wdata = 16'h0099;
    @(negedge clk);
    req_valid = 0;
    chk("R7", "done of first", done, 1);
    chk("R7", "second in bus", cyc_act, 1);
    chk("R7", "second addr", mem_addr, 20'hF0000);
    chk("R9", "wr_err overlapped", wr_err, 1);
    chk("R9", "mem_we overlapped", mem_we, 0);
    @(negedge clk);
    chk("R7", "done of second", done, 1);
    chk("R9", "wr_err cleared", wr_err, 0);
    read1("R7", 20'h00040, 1, 16'h5555);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin even_b[i] = 8'h00; odd_b[i] = 8'h00; end
    even_b[9'h180] = 8'h11;
    odd_b[9'h180]  = 8'h22;
    odd_b[9'h1FF]  = 8'h77;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_even();
    t_byte_odd();
    t_word_even();
    t_split();
    t_rom();
    t_hole();
    t_wrap();
    t_overlap();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule